// File: doc/BRIEF.md
# Switchable-Ratio Card Clock Divider

This block derives a card clock from a fast input clock. A ratio select picks one of two divide ratios. A mode strap picks which pair is on offer: in the default pair the choices are divide-by-2 and divide-by-4, and in the alternate pair they are divide-by-1 and divide-by-2. Which select level means the faster ratio is set by a parameter. The default is that a high select gives the faster ratio.

The select and the strap may change while the clock runs. Both pass through a two-flop synchronizer. A changed value must then stay put for a settling count of input cycles before the divider may act on it, and any further change restarts that count. The divider changes ratio only at the end of a low phase of the output, when its phase counter is at terminal count, so the new ratio always starts from a clean rising edge and no shortened pulse is produced. In the divide-by-1 case the input clock is passed through an AND gate whose enable is registered on the falling input edge. The multiplexing of the slow ratios is done on registered signals.

Top module: `cardclk_divider`

## Requirements
- R1: Default mode (strap low): a high select gives a period of 2 input cycles and a low select gives a period of 4 input cycles. Each has a high phase and a low phase of exactly half the period, and the high phase comes first after each rising edge.
- R2: Alternate mode (strap high): a low select gives a period of 2 input cycles with a 50% duty cycle.
- R3: After the select changes, the output keeps the old ratio for at least 10 input cycles. The new ratio is in steady state within 30 input cycles of the change.
- R4: A second select change made before the settling count ends restarts the count. The output keeps its old ratio for at least 10 input cycles after the latest change.
- R5: The ratio is switched only at the end of a low phase. In default mode no output phase is shorter than one input period. In either mode no phase is longer than two input periods.
- R6: While reset is asserted the output is low. After release, the output starts at the ratio given by the current select and strap, with no settling wait, and its first rising edge comes within 5 input rising edges.
- R7: Alternate mode with a high select passes the input clock through: each output high phase and each low phase lasts exactly half an input period. The gate enable changes only on the falling input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock at crystal rate |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioSel | input | 1 | Ratio select, may change at any time |
| modeAlt | input | 1 | Mode strap: 0 gives the /2 and /4 pair, 1 gives the /1 and /2 pair |
| cardClk | output | 1 | Divided card clock |

## Verification
The assertions assume that `clkIn` runs freely with a duty cycle close to 50%, and that the strap changes only while reset is held, so that every ratio change seen in running is caused by the select. They also assume the select stays put long enough for each settling window to be judged against one known old ratio. The stimulus therefore changes the strap only inside reset sequences. It spaces random select changes at least 30 cycles apart, so that each steady ratio can be measured. The one exception is a directed burst of changes 6 cycles apart, which exercises the restart of the settling count.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    RATIO_1 = 2'd0,
    RATIO_2 = 2'd1,
    RATIO_4 = 2'd2
  } ratio_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic   run;    // divider may run
    logic   init;   // load ratio at once (start-up)
    logic   req;    // settled ratio waiting for a clean swap point
    ratio_e ratio;  // ratio to load
  } divStrobe_t;

  function automatic ratio_e pickRatio(input logic altMode, input logic isFast);
    if (altMode) return isFast ? RATIO_1 : RATIO_2;
    return isFast ? RATIO_2 : RATIO_4;
  endfunction

  // Phase count at which the output period ends (output low there).
  function automatic logic [1:0] lastCount(input ratio_e r);
    case (r)
      RATIO_4: return 2'd3;
      RATIO_2: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // Number of phase counts for which the registered output is high.
  function automatic logic [1:0] highCount(input ratio_e r);
    case (r)
      RATIO_4: return 2'd2;
      RATIO_2: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/cardclk_sync.sv
module cardclk_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int   SETTLE_CYCLES = 10,
  parameter int   SYNC_STAGES   = 2,
  parameter logic FAST_LEVEL    = 1'b1
) (
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       ratioSel,
  input  logic       modeAlt,
  input  logic       swapAck,
  output divStrobe_t strb
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SW  = $clog2(SETTLE_CYCLES + 1);
  localparam int STW = $clog2(SYNC_STAGES + 1);
  localparam logic [SW-1:0]  SETTLE_LAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [STW-1:0] START_READY = STW'(SYNC_STAGES);

  logic [1:0]     syncOut;
  logic [1:0]     pendCode;
  logic [STW-1:0] startCnt;
  logic [SW-1:0]  settleCnt;
  logic           running;
  logic           initPulse;
  logic           reqPend;
  logic           settling;
  ratio_e         tgtRatio;
  logic           codeChanged;

  cardclk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clkIn (clkIn),
    .rstN  (rstN),
    .din   ({modeAlt, ratioSel}),
    .dout  (syncOut)
  );

  function automatic ratio_e decodeCode(input logic [1:0] code);
    return pickRatio(code[1], code[0] == FAST_LEVEL);
  endfunction

  assign codeChanged = running && (syncOut != pendCode);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      startCnt  <= '0;
      settleCnt <= '0;
      running   <= 1'b0;
      initPulse <= 1'b0;
      reqPend   <= 1'b0;
      settling  <= 1'b0;
      pendCode  <= '0;
      tgtRatio  <= RATIO_2;
    end else begin
      initPulse <= 1'b0;
      if (!running) begin
        if (startCnt != START_READY) begin
          startCnt <= startCnt + 1'b1;
        end else begin
          running   <= 1'b1;
          initPulse <= 1'b1;
          pendCode  <= syncOut;
          tgtRatio  <= decodeCode(syncOut);
        end
      end else if (codeChanged) begin
        pendCode  <= syncOut;
        settleCnt <= '0;
        settling  <= 1'b1;
        reqPend   <= 1'b0;
      end else begin
        if (settling) begin
          if (settleCnt == SETTLE_LAST) begin
            settling <= 1'b0;
            reqPend  <= 1'b1;
            tgtRatio <= decodeCode(pendCode);
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        if (swapAck) reqPend <= 1'b0;
      end
    end
  end

  assign strb.run   = running;
  assign strb.init  = initPulse;
  assign strb.req   = reqPend;
  assign strb.ratio = tgtRatio;

  // A swap request appears only once a full settle window has run out.
  p_req_after_settle_r3: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(reqPend) |-> ($past(settling) && $past(settleCnt) == SETTLE_LAST));

  // A fresh code restarts the window and withdraws any waiting request.
  p_restart_window_r4: assert property (@(posedge clkIn) disable iff (!rstN)
    codeChanged |=> (settleCnt == '0 && settling && !reqPend));
endmodule

// File: rtl/cardclk_path.sv
module cardclk_path
  import cardclk_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  divStrobe_t strb,
  output logic       swapAck,
  output logic       cardClk
);
  timeunit 1ns;
  timeprecision 100ps;

  ratio_e     activeRatio;
  logic [1:0] phaseCnt;
  logic [1:0] nextCnt;
  logic       atTerm;
  logic       outReg;
  logic       gateEn;

  assign atTerm  = (phaseCnt == lastCount(activeRatio));
  assign nextCnt = phaseCnt + 2'd1;
  assign swapAck = strb.run && !strb.init && strb.req && atTerm;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      activeRatio <= RATIO_2;
      phaseCnt    <= '0;
      outReg      <= 1'b0;
    end else if (!strb.run) begin
      phaseCnt <= '0;
      outReg   <= 1'b0;
    end else if (strb.init || swapAck) begin
      activeRatio <= strb.ratio;
      phaseCnt    <= '0;
      outReg      <= (strb.ratio != RATIO_1);
    end else if (atTerm) begin
      phaseCnt <= '0;
      outReg   <= (activeRatio != RATIO_1);
    end else begin
      phaseCnt <= nextCnt;
      outReg   <= (nextCnt < highCount(activeRatio));
    end
  end

  // Enable for the pass-through case moves only while clkIn is low.
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= strb.run && (activeRatio == RATIO_1);
  end

  assign cardClk = outReg | (clkIn & gateEn);

  p_swap_low_r5: assert property (@(posedge clkIn) disable iff (!rstN)
    swapAck |-> !outReg);

  p_high_span_r1: assert property (@(posedge clkIn) disable iff (!rstN)
    (outReg && $past(outReg)) |=> !outReg);

  p_gate_div1_r7: assert property (@(posedge clkIn) disable iff (!rstN)
    gateEn |-> (activeRatio == RATIO_1));

  p_idle_low_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    !strb.run |-> (!outReg && !gateEn));
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider #(
  parameter int   SETTLE_CYCLES = 10,
  parameter int   SYNC_STAGES   = 2,
  parameter logic FAST_LEVEL    = 1'b1
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic ratioSel,
  input  logic modeAlt,
  output logic cardClk
);
  timeunit 1ns;
  timeprecision 100ps;

  cardclk_pkg::divStrobe_t strb;
  logic swapAck;

  cardclk_ctrl #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES),
    .FAST_LEVEL    (FAST_LEVEL)
  ) u_ctrl (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .modeAlt  (modeAlt),
    .swapAck  (swapAck),
    .strb     (strb)
  );

  cardclk_path u_path (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .strb    (strb),
    .swapAck (swapAck),
    .cardClk (cardClk)
  );
endmodule

// File: tb/cardclk_divider_bench.sv
module cardclk_divider_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ratioSel = 1'b1;
  logic modeAlt = 1'b0;
  logic cardClk;

  always #2.5 clk = ~clk;  // 200 MHz

  cardclk_divider u_cardclk_divider (
    .clkIn    (clk),
    .rstN     (rstN),
    .ratioSel (ratioSel),
    .modeAlt  (modeAlt),
    .cardClk  (cardClk)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    trackOn = 0;
  bit    skipFirst = 0;
  bit    curLevel = 0;
  int    runLen = 0;
  int    halfIdx = 0;
  int    changeHalf = 0;
  bit    winOn = 0;
  int    winOld = 0;
  string winTag = "R3";
  int    steadyN = 0;
  int    lastHigh = 0;
  int    lastLow = 0;
  int    minHalf = 2;
  bit    modeNow = 0;
  bit    selNow = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Phase length in half input cycles for a mode/select setting.
  function automatic int expHalves(input bit m, input bit s);
    if (m) return s ? 1 : 2;
    return s ? 2 : 4;
  endfunction

  task automatic phaseDone(input bit lvl, input int len);
    check(len <= 4, "R5 phase too long", len, 4);
    check(len >= minHalf, "R5 phase too short", len, minHalf);
    if (lvl) lastHigh = len; else lastLow = len;
    if (winOn && halfIdx < changeHalf + 20)
      check(len == winOld, {winTag, " ratio changed inside settle window"}, len, winOld);
  endtask

  task automatic take(input bit s);
    halfIdx++;
    if (trackOn) begin
      if (s == curLevel) runLen++;
      else begin
        if (skipFirst) skipFirst = 0;
        else phaseDone(curLevel, runLen);
        curLevel = s;
        runLen = 1;
      end
    end
  endtask

  // Sample once in each half of every input period, away from edges.
  always begin
    @(posedge clk); #1; take(cardClk);
    @(negedge clk); #1; take(cardClk);
  end

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic changeSel(input bit v, input string tag);
    @(posedge clk); #2;
    if (v != selNow) begin
      ratioSel = v;
      selNow = v;
      changeHalf = halfIdx;
      winOn = 1;
      winOld = steadyN;
      winTag = tag;
    end
  endtask

  task automatic steadyCheck(input string tag);
    int n;
    n = expHalves(modeNow, selNow);
    check(lastHigh == n, {tag, " high phase"}, lastHigh, n);
    check(lastLow == n, {tag, " low phase"}, lastLow, n);
    steadyN = n;
    winOn = 0;
  endtask

  task automatic doReset(input bit m, input bit s);
    int k;
    @(posedge clk); #2;
    trackOn = 0;
    rstN = 0;
    modeAlt = m;
    ratioSel = s;
    modeNow = m;
    selNow = s;
    waitCycles(3);
    #1 check(cardClk == 1'b0, "R6 low in reset (high half)", cardClk, 0);
    @(negedge clk); #1 check(cardClk == 1'b0, "R6 low in reset (low half)", cardClk, 0);
    @(posedge clk); #2;
    rstN = 1;
    curLevel = 0;
    runLen = 0;
    skipFirst = 1;
    winOn = 0;
    minHalf = m ? 1 : 2;
    trackOn = 1;
    k = 0;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk); #1;
      if (cardClk && k == 0) k = i;
    end
    check(k >= 1 && k <= 5, "R6 first rising edge after release", k, 5);
    waitCycles(30);
  endtask

  initial begin
    void'($urandom(32'h0C1D_2024));
    // Default pair, fast select: /2.
    doReset(0, 1);
    steadyCheck("R1");
    changeSel(0, "R3");
    waitCycles(40);
    steadyCheck("R1");
    // Restart burst: the last change opens a fresh window.
    changeSel(1, "R4");
    waitCycles(6);
    changeSel(0, "R4");
    waitCycles(6);
    changeSel(1, "R4");
    waitCycles(40);
    steadyCheck("R4");
    for (int i = 0; i < 16; i++) begin
      changeSel(1'($urandom_range(0, 1)), "R3");
      waitCycles($urandom_range(30, 70));
      steadyCheck("R1");
    end
    // Alternate pair, fast select: pass-through.
    doReset(1, 1);
    steadyCheck("R7");
    changeSel(0, "R3");
    waitCycles(40);
    steadyCheck("R2");
    changeSel(1, "R3");
    waitCycles(40);
    steadyCheck("R7");
    for (int i = 0; i < 16; i++) begin
      changeSel(1'($urandom_range(0, 1)), "R3");
      waitCycles($urandom_range(30, 70));
      steadyCheck("R2");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule